// File: doc/BRIEF.md
# Stalled Clock Detector

This block watches one clock (the monitored clock) from the domain of a free-running reference clock. When the monitored clock shows no transition for a chosen span of reference cycles, it raises a single "stopped" flag. The flag goes back low as soon as activity is seen again. It does not wait for a timeout to clear.

Two span lengths are available, picked by a select input, and their defaults are in an 8:1 ratio. A clock that stops high is caught, and so is one that stops low. Each monitored clock gets its own instance. The flag is meant to feed a glitch-free clock multiplexer, either as its select or as a hint to shorten its switch-over. The block does not measure frequency or duty cycle. A clock whose period is longer than the selected span may trip the flag.

Activity is captured by toggle flops in the monitored domain, one on each edge. Each toggle is carried into the reference domain through a synchronizer. A change on any synchronized toggle clears a saturating quiet counter.

Top module: `clkmon_stall_detect`

## Requirements
- R1: With `fast_sel` low, `stopped` rises once the monitored clock has been quiet for SLOW_LIMIT (default 80) reference cycles, plus the synchronizer latency, and not earlier.
- R2: A monitored clock that halts at logic high is flagged.
- R3: A monitored clock that halts at logic low is flagged.
- R4: With `fast_sel` high, the quiet span is FAST_LIMIT (default 10) reference cycles.
- R5: When the monitored clock starts toggling again, `stopped` falls within 6 reference cycles.
- R6: While `rst` is high at a reference edge, `stopped` is low after that edge. After release, a full quiet span must elapse before the flag can rise.
- R7: A monitored clock toggling faster than the selected span never raises `stopped`.
- R8: Raising `fast_sel` when the quiet count already exceeds FAST_LIMIT sets `stopped` on the next reference edge.
- R9: The quiet counter saturates at the selected limit and never exceeds SLOW_LIMIT. `stopped` stays high for as long as the clock stays quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; all outputs are in this domain |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| mon_clk | input | 1 | Clock being watched |
| fast_sel | input | 1 | 1 selects the short span (FAST_LIMIT), 0 selects the long span (SLOW_LIMIT) |
| stopped | output | 1 | Registered flag, high while the monitored clock is deemed stopped |

## Verification
The clear on reset is due one reference edge after `rst` is sampled high. A timeout rise is due SLOW_LIMIT or FAST_LIMIT edges after quiet begins, plus up to about four edges of synchronizer and edge-detect latency. A restart clears the flag within that same latency. The rise after a late switch to the short span is due on the very next edge. Because the monitored clock is asynchronous, the scoreboard does not test a single exact cycle for latency-affected results. It queues a low check just before the earliest possible rise and a high check just after the latest, and queues exact-cycle checks only for the reset clear and the select switch.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  // Bits needed to hold values 0..max_val
  function automatic int count_bits(input int max_val);
    int b;
    b = 1;
    while ((1 << b) <= max_val) b++;
    return b;
  endfunction
endpackage

// File: rtl/clkmon_edge_toggle.sv
// Toggle flop in the monitored domain: inverts on each chosen edge of mon_clk.
module clkmon_edge_toggle #(
  parameter bit NEG_EDGE = 1'b0
) (
  input  logic mon_clk,
  output logic tog_o
);
  logic tog_q = 1'b0;

  generate
    if (NEG_EDGE) begin : g_neg
      always_ff @(negedge mon_clk) tog_q <= ~tog_q;
    end else begin : g_pos
      always_ff @(posedge mon_clk) tog_q <= ~tog_q;
    end
  endgenerate

  assign tog_o = tog_q;
endmodule

// File: rtl/clkmon_sync.sv
// Multi-stage synchronizer into the reference domain.
module clkmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/clkmon_quiet_timer.sv
// Saturating quiet counter with registered stopped flag.
module clkmon_quiet_timer
  import clkmon_pkg::*;
#(
  parameter int SLOW_LIMIT = 80,
  parameter int FAST_LIMIT = 10,
  localparam int CW = count_bits(SLOW_LIMIT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fast_sel,
  input  logic          activity,
  output logic          stopped_o,
  output logic [CW-1:0] count_o
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_inc;
  logic [CW:0]   lim;
  logic          stop_q;

  assign lim     = fast_sel ? (CW+1)'(FAST_LIMIT) : (CW+1)'(SLOW_LIMIT);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else if (activity) begin
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else if (cnt_inc >= lim) begin
      cnt_q  <= lim[CW-1:0];
      stop_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_inc[CW-1:0];
    end
  end

  assign stopped_o = stop_q;
  assign count_o   = cnt_q;
endmodule

// File: rtl/clkmon_stall_detect.sv
module clkmon_stall_detect
  import clkmon_pkg::*;
#(
  parameter int SLOW_LIMIT  = 80,
  parameter int FAST_LIMIT  = 10,
  parameter int SYNC_STAGES = 2,
  parameter bit BOTH_EDGES  = 1'b1,
  localparam int EDGES = BOTH_EDGES ? 2 : 1,
  localparam int CW    = count_bits(SLOW_LIMIT)
) (
  input  logic ref_clk,
  input  logic rst,
  input  logic mon_clk,
  input  logic fast_sel,
  output logic stopped
);
  logic [EDGES-1:0] tog;
  logic [EDGES-1:0] sync_q;
  logic [EDGES-1:0] sync_d;
  logic             act;
  logic [CW-1:0]    quiet_cnt;

  for (genvar e = 0; e < EDGES; e++) begin : g_lane
    clkmon_edge_toggle #(.NEG_EDGE(e == 1)) u_tog (
      .mon_clk (mon_clk),
      .tog_o   (tog[e])
    );
    clkmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (ref_clk),
      .rst (rst),
      .d_i (tog[e]),
      .q_o (sync_q[e])
    );
  end

  always_ff @(posedge ref_clk) begin
    if (rst) sync_d <= '0;
    else     sync_d <= sync_q;
  end

  assign act = |(sync_q ^ sync_d);

  clkmon_quiet_timer #(
    .SLOW_LIMIT (SLOW_LIMIT),
    .FAST_LIMIT (FAST_LIMIT)
  ) u_timer (
    .clk       (ref_clk),
    .rst       (rst),
    .fast_sel  (fast_sel),
    .activity  (act),
    .stopped_o (stopped),
    .count_o   (quiet_cnt)
  );
endmodule

// File: rtl/clkmon_stall_detect_chk.sv
module clkmon_stall_detect_chk #(
  parameter int SLOW_LIMIT = 80,
  parameter int FAST_LIMIT = 10,
  parameter int CW = 8
) (
  input logic          ref_clk,
  input logic          rst,
  input logic          fast_sel,
  input logic          act,
  input logic          stopped,
  input logic [CW-1:0] quiet_cnt
);
  // R6: reset clears the flag and the count
  p_reset_clear_r6: assert property (@(posedge ref_clk)
    rst |=> (!stopped && quiet_cnt == '0));

  // R5: seen activity drops the flag on the next edge
  p_clear_on_activity_r5: assert property (@(posedge ref_clk) disable iff (rst)
    act |=> (!stopped && quiet_cnt == '0));

  // R1 / R4: the flag rises only when the count has reached the selected limit
  p_rise_at_limit_r1: assert property (@(posedge ref_clk) disable iff (rst)
    $rose(stopped) |-> (int'(quiet_cnt) == ($past(fast_sel) ? FAST_LIMIT : SLOW_LIMIT)));

  // R9: the counter never passes the long limit
  p_no_overflow_r9: assert property (@(posedge ref_clk) disable iff (rst)
    int'(quiet_cnt) <= SLOW_LIMIT);

  // R9: the flag holds while no activity arrives
  p_hold_while_quiet_r9: assert property (@(posedge ref_clk) disable iff (rst)
    (stopped && !act) |=> stopped);
endmodule

bind clkmon_stall_detect clkmon_stall_detect_chk #(
  .SLOW_LIMIT (SLOW_LIMIT),
  .FAST_LIMIT (FAST_LIMIT),
  .CW         (CW)
) u_chk (
  .ref_clk   (ref_clk),
  .rst       (rst),
  .fast_sel  (fast_sel),
  .act       (act),
  .stopped   (stopped),
  .quiet_cnt (quiet_cnt)
);

// File: tb/test_clkmon_stall_detect.sv
module test_clkmon_stall_detect;
  localparam int SLOW = 80;
  localparam int FAST = 10;

  typedef struct {
    int    due;
    logic  val;
    string req;
  } exp_t;

  logic ref_clk = 1'b0;
  logic rst     = 1'b1;
  logic mon_clk = 1'b0;
  logic mon_en  = 1'b0;
  logic fast_sel = 1'b0;
  logic stopped;

  int   cyc = 0;
  int   n_tests = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  clkmon_stall_detect #(.SLOW_LIMIT(SLOW), .FAST_LIMIT(FAST)) i_clkmon_stall_detect (
    .ref_clk  (ref_clk),
    .rst      (rst),
    .mon_clk  (mon_clk),
    .fast_sel (fast_sel),
    .stopped  (stopped)
  );

  always #4 ref_clk = ~ref_clk;
  always @(posedge ref_clk) cyc <= cyc + 1;

  // Monitored clock: 20 ns period, freezes at its current level when disabled
  always begin
    if (mon_en) begin
      #10;
      if (mon_en) mon_clk = ~mon_clk;
    end else begin
      @(posedge mon_en);
    end
  end

  // Driver side: queue an expected flag value at an absolute cycle
  task automatic expect_at(input int offs, input logic v, input string r);
    exp_t e;
    e.due = cyc + offs;
    e.val = v;
    e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic stop_at(input logic lvl);
    if (mon_clk == lvl) @(mon_clk);
    @(mon_clk);
    mon_en = 1'b0;
    @(negedge ref_clk);
  endtask

  // Monitor: compare at the falling edge once an item is due
  always @(negedge ref_clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      n_tests++;
      if (stopped !== e.val) begin
        n_fail++;
        $display("FAIL %s cycle %0d: stopped=%b expected %b", e.req, cyc, stopped, e.val);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge ref_clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R6: reset state with the clock stopped low
    wait_cyc(3);
    expect_at(0, 1'b0, "R6");
    wait_cyc(2);
    rst = 1'b0;
    expect_at(SLOW - 2, 1'b0, "R6");   // no early rise after reset
    expect_at(SLOW + 4, 1'b1, "R1");   // full long span then rise
    wait_cyc(SLOW + 6);

    // R9: holds while quiet, count saturates
    expect_at(40, 1'b1, "R9");
    wait_cyc(41);

    // R6: reset while flagged clears one edge later
    rst = 1'b1;
    @(posedge ref_clk);
    @(negedge ref_clk);
    expect_at(0, 1'b0, "R6");
    wait_cyc(1);
    rst = 1'b0;

    // R5 / R7: clock runs, flag stays low on the long span
    mon_en = 1'b1;
    expect_at(6, 1'b0, "R5");
    for (int i = 1; i <= 10; i++) expect_at(i * 20, 1'b0, "R7");
    wait_cyc(201);

    // R2 / R1: halt high with the long span
    stop_at(1'b1);
    expect_at(SLOW - 1, 1'b0, "R1");
    expect_at(SLOW + 6, 1'b1, "R2");
    wait_cyc(SLOW + 7);

    // R5: restart, then R7 on the short span
    mon_en = 1'b1;
    expect_at(6, 1'b0, "R5");
    wait_cyc(7);
    fast_sel = 1'b1;
    for (int i = 1; i <= 8; i++) expect_at(i * 12, 1'b0, "R7");
    wait_cyc(97);

    // R3 / R4: halt low with the short span
    stop_at(1'b0);
    expect_at(FAST - 1, 1'b0, "R4");
    expect_at(FAST + 6, 1'b1, "R3");
    wait_cyc(FAST + 7);

    // R4: halt high with the short span
    mon_en = 1'b1;
    expect_at(6, 1'b0, "R5");
    wait_cyc(20);
    stop_at(1'b1);
    expect_at(FAST + 6, 1'b1, "R4");
    wait_cyc(FAST + 7);

    // R8: quiet on the long span past FAST, then switch to the short span
    fast_sel = 1'b0;
    mon_en = 1'b1;
    wait_cyc(20);
    stop_at(1'b0);
    wait_cyc(FAST + 20);
    expect_at(0, 1'b0, "R1");
    wait_cyc(1);
    fast_sel = 1'b1;
    expect_at(1, 1'b1, "R8");
    wait_cyc(4);

    wait (exp_q.size() == 0);
    wait_cyc(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule